// File: doc/BRIEF.md
# Multi-Bank Clock Divider Network

This block turns one fast source clock into three banks of divided clocks and one feedback clock. The source is either a high-rate oscillator input or one of two reference inputs, picked by a bypass control. A shared pre-divider halves or quarters the source. Each bank and the feedback path then apply their own post-divide, which is chosen by a select input. Every output is a 50% duty square wave. All the outputs in a bank are identical copies.

The block runs on a fast sampling clock `clk`. The three source inputs are sampled as data, and each rising edge of the selected source advances the dividers by one step. An active-low clock-stop input parks the three banks low without cutting any pulse short, while the feedback output keeps running. An active-low master-reset/output-enable input clears every divider and drops the output-enable flags. Outputs are modelled as logic levels together with per-bank enable flags. Divide-select changes take effect only at cycle boundaries.

Top module: `bank_divnet`

## Requirements
- R1: `rate_dbl_i` sets the pre-divide to 2 source edges when low and 4 when high, which doubles every bank ratio and the feedback ratio. The pre-divider samples it during reset and at each pre-divider wrap.
- R2: Ratios measured in source rising edges with `rate_dbl_i`=0: banks A and B divide by 4 (bank select 0) or 8 (select 1), and bank C divides by 8 (select 0) or 12 (select 1). With `rate_dbl_i`=1: A and B divide by 8 or 16, and C divides by 16 or 24.
- R3: The feedback ratio is indexed by {`rate_dbl_i`, `fb_sel_i[1]`, `fb_sel_i[0]`} as 0→8, 1→16, 2→12, 3→24, 4→16, 5→32, 6→24, 7→48.
- R4: Every output is high for exactly half of its period. All bits of a bank carry the same value.
- R5: While `clk_stop_n_i` is low, banks A, B and C are held low. Stopping and releasing take effect only at a falling edge of the bank's divided clock, so no output pulse is shortened, and a released bank resumes with its low half. The feedback output ignores `clk_stop_n_i`.
- R6: While `rst` is high or `mr_oe_n_i` is low, all dividers are cleared, every output is low and `oe_o` is 4'b0000. One cycle after both are released, `oe_o` is 4'b1111. All dividers then start together from count zero in their low half, so related ratios rise together.
- R7: With `pll_en_i`=1 the dividers count edges of `vco_clk_i`. With `pll_en_i`=0 they count edges of `ref0_i` when `ref_sel_i`=0 and of `ref1_i` when `ref_sel_i`=1. The unselected source inputs have no effect on any output.
- R8: A change of a bank select or of `fb_sel_i` is taken by the affected divider only at its falling edge. The cycle already in progress completes at the old ratio and the next cycle uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| vco_clk_i | input | 1 | High-rate source used when the loop is enabled |
| ref0_i | input | 1 | Reference source 0 |
| ref1_i | input | 1 | Reference source 1 |
| ref_sel_i | input | 1 | Bypass reference choice (0: ref0, 1: ref1) |
| pll_en_i | input | 1 | 1: count `vco_clk_i`; 0: bypass to selected reference |
| rate_dbl_i | input | 1 | Pre-divide choice (0: ÷2, 1: ÷4) |
| sel_a_i | input | 1 | Bank A ratio select |
| sel_b_i | input | 1 | Bank B ratio select |
| sel_c_i | input | 1 | Bank C ratio select |
| fb_sel_i | input | 2 | Feedback ratio select |
| clk_stop_n_i | input | 1 | Active-low stop for banks A, B, C |
| mr_oe_n_i | input | 1 | Active-low master reset and output disable |
| qa_o | output | NUM_A | Bank A clock copies |
| qb_o | output | NUM_B | Bank B clock copies |
| qc_o | output | NUM_C | Bank C clock copies |
| fb_o | output | 1 | Feedback clock |
| oe_o | output | 4 | Output drive enables {FB, C, B, A} |

## Verification
The bench builds the block with its default fanouts of five, five and four copies, and it compares every copy bit on every step, so a single broken fanout wire is caught. Since the counter width fits the largest half-period of six pre-divided steps, those defaults reach every bank ratio and all eight feedback codes, including the ÷48 end of the table. Stop, output-disable, bypass and live select changes are all placed mid-cycle, both on high and on low halves.

// File: rtl/divnet_pkg.sv
package divnet_pkg;

    localparam int CNT_W    = 3;
    localparam int PRE_W    = 2;
    localparam int NUM_DIV  = 4;
    localparam int NUM_BANK = 3;
    localparam int FB_IDX   = 3;

    typedef enum logic [1:0] {
        KIND_AB = 2'd0,
        KIND_C  = 2'd1,
        KIND_FB = 2'd2
    } div_kind_e;

    typedef struct packed {
        logic       a;
        logic       b;
        logic       c;
        logic [1:0] fb;
    } sel_set_t;

    // Half period, counted in pre-divided steps.
    function automatic logic [CNT_W-1:0] post_half(div_kind_e kind, logic [1:0] code);
        logic [CNT_W-1:0] h;
        case (kind)
            KIND_AB: h = code[0] ? CNT_W'(2) : CNT_W'(1);
            KIND_C:  h = code[0] ? CNT_W'(3) : CNT_W'(2);
            default: begin
                case (code)
                    2'd0:    h = CNT_W'(2);
                    2'd1:    h = CNT_W'(4);
                    2'd2:    h = CNT_W'(3);
                    default: h = CNT_W'(6);
                endcase
            end
        endcase
        return h;
    endfunction

    function automatic div_kind_e kind_of(int idx);
        if (idx == FB_IDX) return KIND_FB;
        if (idx == 2)      return KIND_C;
        return KIND_AB;
    endfunction

endpackage

// File: rtl/divnet_src_tick.sv
module divnet_src_tick (
    input  logic clk,
    input  logic rst,
    input  logic pll_en_i,
    input  logic ref_sel_i,
    input  logic vco_i,
    input  logic ref0_i,
    input  logic ref1_i,
    output logic tick_o
);
    logic src_w;
    logic s1_q;
    logic s2_q;

    always_comb begin
        if (pll_en_i) src_w = vco_i;
        else          src_w = ref_sel_i ? ref1_i : ref0_i;
    end

    // During reset both stages follow the source, so release makes no false edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= src_w;
            s2_q <= src_w;
        end else begin
            s1_q <= src_w;
            s2_q <= s1_q;
        end
    end

    assign tick_o = s1_q & ~s2_q;
endmodule

// File: rtl/divnet_prediv.sv
module divnet_prediv
    import divnet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dbl_i,
    input  logic tick_i,
    output logic pre_tick_o
);
    logic [PRE_W-1:0] cnt_q;
    logic             dbl_q;
    logic [PRE_W-1:0] last_w;
    logic             wrap_w;

    assign last_w = dbl_q ? PRE_W'(3) : PRE_W'(1);
    assign wrap_w = tick_i && (cnt_q == last_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dbl_q <= dbl_i;
        end else if (tick_i) begin
            if (wrap_w) begin
                cnt_q <= '0;
                dbl_q <= dbl_i;
            end else begin
                cnt_q <= cnt_q + PRE_W'(1);
            end
        end
    end

    assign pre_tick_o = wrap_w;
endmodule

// File: rtl/divnet_half_div.sv
module divnet_half_div
    import divnet_pkg::*;
#(
    parameter div_kind_e KIND = KIND_AB
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pre_tick_i,
    input  logic [1:0] code_i,
    output logic       div_o,
    output logic [1:0] code_q_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_w;
    logic [1:0]       code_q;
    logic             div_q;
    logic             wrap_w;

    assign half_w = post_half(KIND, code_q);
    assign wrap_w = pre_tick_i && (cnt_q == half_w - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            div_q  <= 1'b0;
            code_q <= code_i;
        end else if (pre_tick_i) begin
            if (wrap_w) begin
                cnt_q <= '0;
                div_q <= ~div_q;
                // New ratio only at the end of a full cycle.
                if (div_q) code_q <= code_i;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign div_o    = div_q;
    assign code_q_o = code_q;
endmodule

// File: rtl/divnet_stop_gate.sv
module divnet_stop_gate (
    input  logic clk,
    input  logic rst,
    input  logic stop_req_i,
    input  logic div_i,
    output logic q_o
);
    logic div_d_q;
    logic parked_q;
    logic fell_w;

    assign fell_w = div_d_q & ~div_i;

    // The park state changes only right after a falling edge, while the divided
    // clock sits low for at least two more cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            div_d_q  <= 1'b0;
            parked_q <= stop_req_i;
        end else begin
            div_d_q <= div_i;
            if (fell_w) parked_q <= stop_req_i;
        end
    end

    assign q_o = div_i & ~parked_q;
endmodule

// File: rtl/bank_divnet.sv
module bank_divnet
    import divnet_pkg::*;
#(
    parameter int NUM_A = 5,
    parameter int NUM_B = 5,
    parameter int NUM_C = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vco_clk_i,
    input  logic             ref0_i,
    input  logic             ref1_i,
    input  logic             ref_sel_i,
    input  logic             pll_en_i,
    input  logic             rate_dbl_i,
    input  logic             sel_a_i,
    input  logic             sel_b_i,
    input  logic             sel_c_i,
    input  logic [1:0]       fb_sel_i,
    input  logic             clk_stop_n_i,
    input  logic             mr_oe_n_i,
    output logic [NUM_A-1:0] qa_o,
    output logic [NUM_B-1:0] qb_o,
    output logic [NUM_C-1:0] qc_o,
    output logic             fb_o,
    output logic [3:0]       oe_o
);
    logic                core_rst;
    logic                tick_w;
    logic                pre_tick_w;
    logic                oe_q;
    sel_set_t            sel_w;
    logic [1:0]          code_w   [NUM_DIV];
    logic [1:0]          code_q_w [NUM_DIV];
    logic [NUM_DIV-1:0]  div_w;
    logic [NUM_BANK-1:0] bank_w;

    assign core_rst = rst | ~mr_oe_n_i;

    assign sel_w.a  = sel_a_i;
    assign sel_w.b  = sel_b_i;
    assign sel_w.c  = sel_c_i;
    assign sel_w.fb = fb_sel_i;

    assign code_w[0]      = {1'b0, sel_w.a};
    assign code_w[1]      = {1'b0, sel_w.b};
    assign code_w[2]      = {1'b0, sel_w.c};
    assign code_w[FB_IDX] = sel_w.fb;

    divnet_src_tick u_src (
        .clk       (clk),
        .rst       (core_rst),
        .pll_en_i  (pll_en_i),
        .ref_sel_i (ref_sel_i),
        .vco_i     (vco_clk_i),
        .ref0_i    (ref0_i),
        .ref1_i    (ref1_i),
        .tick_o    (tick_w)
    );

    divnet_prediv u_pre (
        .clk        (clk),
        .rst        (core_rst),
        .dbl_i      (rate_dbl_i),
        .tick_i     (tick_w),
        .pre_tick_o (pre_tick_w)
    );

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
        localparam div_kind_e K = kind_of(i);
        divnet_half_div #(.KIND(K)) u_div (
            .clk        (clk),
            .rst        (core_rst),
            .pre_tick_i (pre_tick_w),
            .code_i     (code_w[i]),
            .div_o      (div_w[i]),
            .code_q_o   (code_q_w[i])
        );
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_gate
        divnet_stop_gate u_gate (
            .clk        (clk),
            .rst        (core_rst),
            .stop_req_i (~clk_stop_n_i),
            .div_i      (div_w[b]),
            .q_o        (bank_w[b])
        );
    end

    always_ff @(posedge clk) begin
        oe_q <= ~core_rst;
    end

    assign qa_o = {NUM_A{bank_w[0] & oe_q}};
    assign qb_o = {NUM_B{bank_w[1] & oe_q}};
    assign qc_o = {NUM_C{bank_w[2] & oe_q}};
    assign fb_o = div_w[FB_IDX] & oe_q;
    assign oe_o = {4{oe_q}};
endmodule

// File: rtl/divnet_checker.sv
module divnet_checker
    import divnet_pkg::*;
#(
    parameter int NUM_A = 5,
    parameter int NUM_B = 5,
    parameter int NUM_C = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               mr_oe_n,
    input logic [NUM_A-1:0]   qa,
    input logic [NUM_B-1:0]   qb,
    input logic [NUM_C-1:0]   qc,
    input logic               fb,
    input logic [3:0]         oe,
    input logic [NUM_DIV-1:0] div,
    input logic [1:0]         code_q [NUM_DIV]
);
    a_r6_disable_quiet: assert property (@(posedge clk) disable iff (rst)
        !mr_oe_n |=> (oe == 4'b0000 && qa == '0 && qb == '0 && qc == '0 && !fb));

    a_r4_bank_copies: assert property (@(posedge clk) disable iff (rst)
        ($countones(qa) == 0 || $countones(qa) == NUM_A) &&
        ($countones(qb) == 0 || $countones(qb) == NUM_B) &&
        ($countones(qc) == 0 || $countones(qc) == NUM_C));

    a_r5_gate_only_lowers: assert property (@(posedge clk) disable iff (rst)
        (qa[0] != div[0] || qb[0] != div[1] || qc[0] != div[2]) |->
        ((qa[0] == 1'b0 || qa[0] == div[0]) &&
         (qb[0] == 1'b0 || qb[0] == div[1]) &&
         (qc[0] == 1'b0 || qc[0] == div[2])));

    a_r4_fb_min_high: assert property (@(posedge clk) disable iff (rst || !mr_oe_n)
        $rose(fb) |=> fb);

    a_r5_bank_min_high: assert property (@(posedge clk) disable iff (rst || !mr_oe_n)
        $rose(qa[0]) |=> qa[0]);

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_code
        a_r8_code_at_fall: assert property (@(posedge clk) disable iff (rst || !mr_oe_n)
            ($past(mr_oe_n) && !$past(rst) && code_q[i] != $past(code_q[i])) |->
            ($past(div[i]) && !div[i]));
    end
endmodule

bind bank_divnet divnet_checker #(
    .NUM_A (NUM_A),
    .NUM_B (NUM_B),
    .NUM_C (NUM_C)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mr_oe_n (mr_oe_n_i),
    .qa      (qa_o),
    .qb      (qb_o),
    .qc      (qc_o),
    .fb      (fb_o),
    .oe      (oe_o),
    .div     (div_w),
    .code_q  (code_q_w)
);

// File: tb/test_bank_divnet.sv
module test_bank_divnet;
    localparam int NA = 5;
    localparam int NB = 5;
    localparam int NC = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic [2:0]    src_v = 3'b000;   // {ref1, ref0, vco}
    logic          ref_sel = 1'b0;
    logic          pll_en = 1'b1;
    logic          rate_dbl = 1'b0;
    logic          sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
    logic [1:0]    fb_sel = 2'b00;
    logic          stop_n = 1'b1;
    logic          mr_oe_n = 1'b1;
    logic [NA-1:0] qa;
    logic [NB-1:0] qb;
    logic [NC-1:0] qc;
    logic          fb;
    logic [3:0]    oe;

    bank_divnet #(.NUM_A(NA), .NUM_B(NB), .NUM_C(NC)) i_bank_divnet (
        .clk(clk), .rst(rst), .vco_clk_i(src_v[0]), .ref0_i(src_v[1]), .ref1_i(src_v[2]),
        .ref_sel_i(ref_sel), .pll_en_i(pll_en), .rate_dbl_i(rate_dbl),
        .sel_a_i(sel_a), .sel_b_i(sel_b), .sel_c_i(sel_c), .fb_sel_i(fb_sel),
        .clk_stop_n_i(stop_n), .mr_oe_n_i(mr_oe_n),
        .qa_o(qa), .qb_o(qb), .qc_o(qc), .fb_o(fb), .oe_o(oe)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model, counted in source rising edges.
    int lvl [4];
    int cnt [4];
    int hlf [4];
    bit stp [3];
    bit oe_m = 1'b0;

    function automatic int exp_half(int i);
        int p;
        int post;
        p = rate_dbl ? 4 : 2;
        case (i)
            0: post = sel_a ? 2 : 1;
            1: post = sel_b ? 2 : 1;
            2: post = sel_c ? 3 : 2;
            default: case (fb_sel)
                2'd0: post = 2;
                2'd1: post = 4;
                2'd2: post = 3;
                default: post = 6;
            endcase
        endcase
        return post * p;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            lvl[i] = 0; cnt[i] = 0; hlf[i] = exp_half(i);
        end
        for (int b = 0; b < 3; b++) stp[b] = !stop_n;
    endtask

    task automatic model_edge();
        if (!oe_m) begin
            model_reset();
            return;
        end
        for (int i = 0; i < 4; i++) begin
            cnt[i]++;
            if (cnt[i] == hlf[i]) begin
                cnt[i] = 0;
                if (lvl[i] == 1) begin
                    lvl[i] = 0;
                    hlf[i] = exp_half(i);
                    if (i < 3) stp[i] = !stop_n;
                end else begin
                    lvl[i] = 1;
                end
            end
        end
    endtask

    task automatic check_bit(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic ea, eb, ec, ef;
        ea = (lvl[0] == 1) && !stp[0] && oe_m;
        eb = (lvl[1] == 1) && !stp[1] && oe_m;
        ec = (lvl[2] == 1) && !stp[2] && oe_m;
        ef = (lvl[3] == 1) && oe_m;
        check_bit(tag, "bank A", 8'(qa), 8'({NA{ea}}));
        check_bit(tag, "bank B", 8'(qb), 8'({NB{eb}}));
        check_bit(tag, "bank C", 8'(qc), 8'({NC{ec}}));
        check_bit(tag, "feedback", 8'(fb), 8'(ef));
        check_bit(tag, "enables", 8'(oe), 8'({4{oe_m}}));
    endtask

    // One source cycle on input idx; the other two inputs pulse twice meanwhile.
    task automatic src_step(int idx, string tag);
        @(negedge clk);
        src_v[idx] = 1'b1;
        model_edge();
        repeat (4) @(negedge clk);
        src_v[idx] = 1'b0;
        for (int k = 0; k < 2; k++) begin
            for (int j = 0; j < 3; j++) if (j != idx) src_v[j] = 1'b1;
            @(negedge clk);
            for (int j = 0; j < 3; j++) if (j != idx) src_v[j] = 1'b0;
            @(negedge clk);
        end
        check_all(tag);
    endtask

    task automatic run(int n, int idx, string tag);
        for (int s = 0; s < n; s++) src_step(idx, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        src_v = 3'b000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        oe_m = 1'b1;
        @(negedge clk);
    endtask

    // R6: reset state
    task automatic t_reset_state();
        do_reset();
        check_all("R6 reset state");
    endtask

    // R2, R4, R1: bank ratios under both pre-divides
    task automatic t_bank_ratios();
        for (int g = 0; g < 2; g++) begin
            for (int p = 0; p < 2; p++) begin
                rate_dbl = g[0];
                sel_a = p[0]; sel_b = !p[0]; sel_c = p[0];
                do_reset();
                run(50, 0, "R2 R4 R1 bank ratio");
            end
        end
    endtask

    // R3, R1: every feedback code
    task automatic t_fb_table();
        sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b0;
        for (int c = 0; c < 8; c++) begin
            rate_dbl = c[2];
            fb_sel = c[1:0];
            do_reset();
            run(c[2] ? 100 : 50, 0, "R3 feedback table");
        end
    endtask

    // R5: stop on a high half, release on a high half, feedback keeps running
    task automatic t_stop();
        rate_dbl = 1'b0; sel_a = 1'b0; sel_b = 1'b1; sel_c = 1'b1; fb_sel = 2'd3;
        stop_n = 1'b1;
        do_reset();
        run(3, 0, "R5 before stop");
        stop_n = 1'b0;
        run(30, 0, "R5 stopped");
        stop_n = 1'b1;
        run(1, 0, "R5 release");
        run(30, 0, "R5 resumed");
        stop_n = 1'b0;
        do_reset();
        run(10, 0, "R5 stopped from reset");
        stop_n = 1'b1;
        run(20, 0, "R5 resumed from reset");
    endtask

    // R6: output disable mid-run, then aligned restart
    task automatic t_oe();
        rate_dbl = 1'b0; sel_a = 1'b0; sel_b = 1'b1; sel_c = 1'b0; fb_sel = 2'd0;
        do_reset();
        run(7, 0, "R6 before disable");
        @(negedge clk);
        mr_oe_n = 1'b0;
        oe_m = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        check_all("R6 disabled");
        run(5, 0, "R6 held while disabled");
        @(negedge clk);
        mr_oe_n = 1'b1;
        model_reset();
        oe_m = 1'b1;
        @(negedge clk);
        check_all("R6 re-enabled");
        run(30, 0, "R6 aligned restart");
    endtask

    // R7: bypass to each reference with the others toggling
    task automatic t_bypass();
        rate_dbl = 1'b0; sel_a = 1'b1; sel_b = 1'b0; sel_c = 1'b0; fb_sel = 2'd1;
        pll_en = 1'b0;
        ref_sel = 1'b0;
        do_reset();
        run(40, 1, "R7 bypass ref0");
        ref_sel = 1'b1;
        do_reset();
        run(40, 2, "R7 bypass ref1");
        pll_en = 1'b1;
        ref_sel = 1'b0;
        do_reset();
        run(20, 0, "R7 loop source");
    endtask

    // R8: live select changes
    task automatic t_sel_change();
        rate_dbl = 1'b0; sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b0; fb_sel = 2'd0;
        do_reset();
        run(3, 0, "R8 before change");
        sel_a = 1'b1; sel_c = 1'b1; fb_sel = 2'd3;
        run(40, 0, "R8 after change");
        sel_b = 1'b1; sel_a = 1'b0; fb_sel = 2'd2;
        run(2, 0, "R8 second change");
        sel_c = 1'b0;
        run(40, 0, "R8 settled");
    endtask

    initial begin
        t_reset_state();
        t_bank_ratios();
        t_fb_table();
        t_stop();
        t_oe();
        t_bypass();
        t_sel_change();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule